// File: doc/BRIEF.md
# Stereo Volume Command Generator

This block turns volume and mute requests for a multichannel DAC into attenuation register writes. It keeps a 7-bit level and a mute flag for each of eight output channels and for two master sides, left and right. It also keeps one digital master attenuation value. When a request changes the stored state, the block works out the new attenuation code and sends the register writes that follow from it. The writes go out on a command port with valid/ready handshaking, and a downstream serial writer consumes them.

Requests arrive one at a time on a request port that also uses valid/ready. While a write sequence is still draining, the request port deasserts ready. No request is lost, and a request that would leave the stored state unchanged produces no writes.

A channel code mixes the channel level with the level of its master side, passed through a logarithmic table. Every value is sent twice to the same register: first as a pre-latch, then again with the update bits set.

Top module: `volCmdGen`

## Requirements
- R1: Reset sets every channel and master mute flag, clears all levels and the digital master value, and holds reqReady and cmdValid low. After reset, the block emits the sequence for channels 0 to 7 in ascending order, each with code 0. reqReady stays low until that sequence has been consumed.
- R2: If a channel's own mute flag is set, or the mute flag of its master side is set, that channel's code is 0.
- R3: Otherwise the code is 127 minus T(i). The index i is (channel level × master level) / 127, truncated and masked to 8 bits. T(0) = 127, and T(x) = round(20·log10(255/x)) for x from 1 to 255.
- R4: A channel sequence for channel n is two commands, both with cmdAddr = n. The first carries cmdData = code. The second carries cmdData = code | 0x180.
- R5: Even channels use master side 0 and odd channels use master side 1.
- R6: A change to a master level or master mute reissues the sequence for every channel of that side, in ascending channel order (side, side+2, side+4, side+6). That is 8 commands.
- R7: A digital master request v maps to a value d. For v = 0, d = 0. For any other v, d = (v + 127) & 0xFF. The block then writes d and then d | 0x100, both to cmdAddr 0x11.
- R8: Request encoding is as follows. reqKind 0 sets a channel level (reqValue[6:0]). reqKind 1 sets a channel mute (reqValue[0], where 1 means muted). reqKind 2 sets a master level and reqKind 3 sets a master mute; for both, the side is reqIndex[0]. reqKind 4 sets the digital master (reqValue). A request whose value equals the stored state, or whose reqKind is 5 to 7, is accepted and produces no command.
- R9: While a sequence is pending, reqReady is low and the request is held. Once the sequence completes, the held request is accepted, and its commands follow the earlier sequence.
- R10: While cmdValid is high and cmdReady is low, cmdValid, cmdAddr and cmdData hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqKind | input | 3 | Request kind (see R8) |
| reqIndex | input | 3 | Channel number, or master side in bit 0 |
| reqValue | input | 8 | Level, mute flag or digital master value |
| cmdValid | output | 1 | Command present |
| cmdReady | input | 1 | Downstream writer takes the command |
| cmdAddr | output | 5 | Target register address |
| cmdData | output | 9 | Register data |

## Verification
A request is taken on the edge where reqValid and reqReady are both high. The first command of its sequence is valid right after that edge, and each later command appears one edge after the previous one is taken with cmdReady high. So a channel sequence lasts 2 cycles and a master sequence lasts 8 cycles under full readiness. The bench samples on the falling edge and records every command taken. After each request it waits a window longer than the longest sequence, then compares the recorded commands in order against a reference model's list. For the stalled cases it holds cmdReady low and checks at fixed falling edges that the command port is frozen and that reqReady stays low.

// File: rtl/volCmdPkg.sv
package volCmdPkg;

  localparam int LVL_W  = 7;
  localparam int CODE_W = 7;
  localparam int DIG_W  = 8;
  localparam int LUT_N  = 256;

  typedef enum logic [2:0] {
    KIND_CH_LVL  = 3'd0,
    KIND_CH_MUTE = 3'd1,
    KIND_MS_LVL  = 3'd2,
    KIND_MS_MUTE = 3'd3,
    KIND_DIG     = 3'd4
  } reqKindT;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_PRE  = 2'd2,
    ST_UPD  = 2'd3
  } ctrlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic applyReq;   // commit the accepted request into storage
    logic updPhase;   // second write of a pair
    logic digSel;     // sequence targets the digital master register
  } ctrlStrobeT;

  typedef logic [LUT_N-1:0][CODE_W-1:0] lutT;

  // log attenuation table, entry 0 pinned to the largest value
  function automatic lutT buildLut();
    lutT t;
    t[0] = CODE_W'(127);
    for (int x = 1; x < LUT_N; x++) begin
      t[x] = CODE_W'($rtoi(20.0 * $log10(255.0 / real'(x)) + 0.5));
    end
    return t;
  endfunction

endpackage

// File: rtl/volDatapath.sv
module volDatapath
  import volCmdPkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int ADDR_W   = 5,
  parameter int DIG_ADDR = 17,
  localparam int CH_W    = $clog2(NUM_CHAN),
  localparam int DATA_W  = DIG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [2:0]        reqKind,
  input  logic [CH_W-1:0]   reqIndex,
  input  logic [DIG_W-1:0]  reqValue,
  output logic              reqChanged,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  localparam lutT ATTEN_LUT = buildLut();
  localparam int  PROD_W    = 2 * LVL_W;

  logic [LVL_W-1:0]    chLvl [NUM_CHAN];
  logic [NUM_CHAN-1:0] chMute;
  logic [LVL_W-1:0]    msLvl [2];
  logic [1:0]          msMute;
  logic [DIG_W-1:0]    digVol;

  logic [DIG_W-1:0]    digNew;
  logic                reqSide;
  logic [LVL_W-1:0]    newLvl;

  assign reqSide = reqIndex[0];
  assign newLvl  = reqValue[LVL_W-1:0];
  assign digNew  = (reqValue == '0) ? '0 : DIG_W'(reqValue + DIG_W'(127));

  always_comb begin
    case (reqKind)
      KIND_CH_LVL:  reqChanged = (chLvl[reqIndex] != newLvl);
      KIND_CH_MUTE: reqChanged = (chMute[reqIndex] != reqValue[0]);
      KIND_MS_LVL:  reqChanged = (msLvl[reqSide] != newLvl);
      KIND_MS_MUTE: reqChanged = (msMute[reqSide] != reqValue[0]);
      KIND_DIG:     reqChanged = (digVol != digNew);
      default:      reqChanged = 1'b0;
    endcase
  end

  // per-channel storage
  for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chLvl[c]  <= '0;
        chMute[c] <= 1'b1;
      end else if (strobe.applyReq && reqIndex == CH_W'(c)) begin
        if (reqKind == KIND_CH_LVL)  chLvl[c]  <= newLvl;
        if (reqKind == KIND_CH_MUTE) chMute[c] <= reqValue[0];
      end
    end
  end

  // per-side master storage
  for (genvar s = 0; s < 2; s++) begin : gSide
    always_ff @(posedge clk) begin
      if (!rstN) begin
        msLvl[s]  <= '0;
        msMute[s] <= 1'b1;
      end else if (strobe.applyReq && reqSide == 1'(s)) begin
        if (reqKind == KIND_MS_LVL)  msLvl[s]  <= newLvl;
        if (reqKind == KIND_MS_MUTE) msMute[s] <= reqValue[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                        digVol <= '0;
    else if (strobe.applyReq && reqKind == KIND_DIG)  digVol <= digNew;
  end

  // attenuation code of the channel under sequence
  logic              curSide;
  logic [PROD_W-1:0] prod;
  logic [7:0]        lutIdx;
  logic [CODE_W-1:0] chCode;

  assign curSide = chanSel[0];
  always_comb begin
    prod   = PROD_W'(chLvl[chanSel]) * PROD_W'(msLvl[curSide]);
    lutIdx = 8'(prod / PROD_W'(127));
    chCode = (chMute[chanSel] || msMute[curSide]) ? '0
           : CODE_W'(127) - ATTEN_LUT[lutIdx];
  end

  always_comb begin
    if (strobe.digSel) begin
      cmdAddr = ADDR_W'(DIG_ADDR);
      cmdData = {strobe.updPhase, digVol};
    end else begin
      cmdAddr = ADDR_W'(chanSel);
      cmdData = {strobe.updPhase, strobe.updPhase, chCode};
    end
  end

endmodule

// File: rtl/volControl.sv
module volControl
  import volCmdPkg::*;
#(
  parameter int NUM_CHAN = 8,
  localparam int CH_W    = $clog2(NUM_CHAN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      reqKind,
  input  logic [CH_W-1:0] reqIndex,
  input  logic            reqChanged,
  input  logic            cmdReady,
  output logic            reqReady,
  output logic            cmdValid,
  output ctrlStrobeT      strobe,
  output logic [CH_W-1:0] chanSel
);

  ctrlStateT       st;
  logic [CH_W-1:0] chanPtr;
  logic [CH_W-1:0] lastChan;
  logic            stepTwo;
  logic            digMode;
  logic [CH_W-1:0] sideBase;

  assign sideBase = {{(CH_W-1){1'b0}}, reqIndex[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_BOOT;
      chanPtr  <= '0;
      lastChan <= CH_W'(NUM_CHAN - 1);
      stepTwo  <= 1'b0;
      digMode  <= 1'b0;
    end else begin
      case (st)
        ST_BOOT: st <= ST_PRE;
        ST_IDLE: begin
          if (reqValid && reqChanged) begin
            st <= ST_PRE;
            case (reqKind)
              KIND_CH_LVL, KIND_CH_MUTE: begin
                chanPtr  <= reqIndex;
                lastChan <= reqIndex;
                stepTwo  <= 1'b0;
                digMode  <= 1'b0;
              end
              KIND_MS_LVL, KIND_MS_MUTE: begin
                chanPtr  <= sideBase;
                lastChan <= sideBase + CH_W'(NUM_CHAN - 2);
                stepTwo  <= 1'b1;
                digMode  <= 1'b0;
              end
              KIND_DIG: digMode <= 1'b1;
              default:  st <= ST_IDLE;
            endcase
          end
        end
        ST_PRE: if (cmdReady) st <= ST_UPD;
        ST_UPD: begin
          if (cmdReady) begin
            if (!digMode && chanPtr != lastChan) begin
              chanPtr <= chanPtr + (stepTwo ? CH_W'(2) : CH_W'(1));
              st      <= ST_PRE;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign reqReady        = (st == ST_IDLE);
  assign cmdValid        = (st == ST_PRE) || (st == ST_UPD);
  assign strobe.applyReq = (st == ST_IDLE) && reqValid && reqChanged;
  assign strobe.updPhase = (st == ST_UPD);
  assign strobe.digSel   = digMode;
  assign chanSel         = chanPtr;

endmodule

// File: rtl/volCmdGen.sv
module volCmdGen
  import volCmdPkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int ADDR_W   = 5,
  parameter int DIG_ADDR = 17,
  localparam int CH_W    = $clog2(NUM_CHAN),
  localparam int DATA_W  = DIG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqKind,
  input  logic [CH_W-1:0]   reqIndex,
  input  logic [DIG_W-1:0]  reqValue,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  ctrlStrobeT      strobe;
  logic [CH_W-1:0] chanSel;
  logic            reqChanged;

  volControl #(.NUM_CHAN(NUM_CHAN)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqIndex(reqIndex), .reqChanged(reqChanged), .cmdReady(cmdReady),
    .reqReady(reqReady), .cmdValid(cmdValid), .strobe(strobe),
    .chanSel(chanSel)
  );

  volDatapath #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .DIG_ADDR(DIG_ADDR)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanSel(chanSel),
    .reqKind(reqKind), .reqIndex(reqIndex), .reqValue(reqValue),
    .reqChanged(reqChanged), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

endmodule

// File: rtl/volCmdChecker.sv
module volCmdChecker #(
  parameter int NUM_CHAN = 8,
  parameter int ADDR_W   = 5,
  parameter int DIG_ADDR = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [8:0]        cmdData
);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdAddr) && $stable(cmdData));

  a_r4_update_follows: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdAddr < ADDR_W'(NUM_CHAN) && cmdData[8:7] == 2'b00
    |=> cmdValid && cmdAddr == $past(cmdAddr) && cmdData == ($past(cmdData) | 9'h180));

  a_r7_dig_update: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdAddr == ADDR_W'(DIG_ADDR) && !cmdData[8]
    |=> cmdValid && cmdAddr == ADDR_W'(DIG_ADDR) && cmdData == {1'b1, $past(cmdData[7:0])});

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady);

  a_r4_addr_legal: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdAddr < ADDR_W'(NUM_CHAN)) || (cmdAddr == ADDR_W'(DIG_ADDR)));

endmodule

bind volCmdGen volCmdChecker #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .DIG_ADDR(DIG_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdAddr(cmdAddr), .cmdData(cmdData)
);

// File: tb/tb_volCmdGen.sv
module tb_volCmdGen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [2:0] reqKind = '0;
  logic [2:0] reqIndex = '0;
  logic [7:0] reqValue = '0;
  logic       cmdValid;
  logic       cmdReady = 1'b1;
  logic [4:0] cmdAddr;
  logic [8:0] cmdData;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  volCmdGen dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqIndex(reqIndex), .reqValue(reqValue),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  // reference model state
  int mLvl[8];
  int mMute[8];
  int sLvl[2];
  int sMute[2];
  int mDig;

  logic [13:0] seenQ[$];
  logic [13:0] expQ[$];

  always @(negedge clk) begin
    if (rstN && cmdValid && cmdReady) seenQ.push_back({cmdAddr, cmdData});
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lutRef(int x);
    real d;
    if (x == 0) return 127;
    d = 20.0 * $log10(255.0 / real'(x));
    for (int y = 0; y < 128; y++) begin
      if ((d - real'(y)) < 0.5 && (real'(y) - d) <= 0.5) return y;
    end
    return 0;
  endfunction

  function automatic int codeRef(int ch);
    int s;
    s = ch % 2;
    if (mMute[ch] != 0 || sMute[s] != 0) return 0;
    return 127 - lutRef(((mLvl[ch] * sLvl[s]) / 127) & 255);
  endfunction

  task automatic pushChan(input int ch);
    int c;
    c = codeRef(ch);
    expQ.push_back({5'(ch), 2'b00, 7'(c)});
    expQ.push_back({5'(ch), 2'b11, 7'(c)});
  endtask

  task automatic modelApply(input int kind, input int idx, input int val);
    int d;
    case (kind)
      0: if (mLvl[idx] != (val & 127)) begin mLvl[idx] = val & 127; pushChan(idx); end
      1: if (mMute[idx] != (val & 1)) begin mMute[idx] = val & 1; pushChan(idx); end
      2: if (sLvl[idx % 2] != (val & 127)) begin
           sLvl[idx % 2] = val & 127;
           for (int k = idx % 2; k < 8; k += 2) pushChan(k);
         end
      3: if (sMute[idx % 2] != (val & 1)) begin
           sMute[idx % 2] = val & 1;
           for (int k = idx % 2; k < 8; k += 2) pushChan(k);
         end
      4: begin
           d = (val == 0) ? 0 : ((val + 127) & 255);
           if (d != mDig) begin
             mDig = d;
             expQ.push_back({5'd17, 1'b0, 8'(d)});
             expQ.push_back({5'd17, 1'b1, 8'(d)});
           end
         end
      default: ;
    endcase
  endtask

  task automatic sendReq(input int kind, input int idx, input int val);
    @(posedge clk); #1;
    reqValid = 1'b1; reqKind = 3'(kind); reqIndex = 3'(idx); reqValue = 8'(val);
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    modelApply(kind, idx, val);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic compareQ(input string tag);
    chk(seenQ.size() == expQ.size(), {tag, " count"}, seenQ.size(), expQ.size());
    if (seenQ.size() == expQ.size()) begin
      for (int i = 0; i < seenQ.size(); i++)
        chk(seenQ[i] == expQ[i], tag, int'(seenQ[i]), int'(expQ[i]));
    end
    seenQ.delete();
    expQ.delete();
  endtask

  // {kind, index, value}
  localparam int N_STIM = 22;
  localparam logic [13:0] STIM [N_STIM] = '{
    {3'd3, 3'd0, 8'd0},   {3'd3, 3'd1, 8'd0},   {3'd1, 3'd0, 8'd0},
    {3'd2, 3'd0, 8'd127}, {3'd0, 3'd0, 8'd127}, {3'd0, 3'd0, 8'd127},
    {3'd1, 3'd1, 8'd0},   {3'd2, 3'd1, 8'd64},  {3'd0, 3'd1, 8'd100},
    {3'd0, 3'd2, 8'd90},  {3'd2, 3'd0, 8'd127}, {3'd2, 3'd0, 8'd40},
    {3'd0, 3'd0, 8'd1},   {3'd3, 3'd0, 8'd1},   {3'd4, 3'd0, 8'd128},
    {3'd4, 3'd0, 8'd128}, {3'd4, 3'd0, 8'd1},   {3'd4, 3'd0, 8'd0},
    {3'd4, 3'd0, 8'd0},   {3'd5, 3'd2, 8'd9},   {3'd0, 3'd7, 8'd127},
    {3'd1, 3'd7, 8'd0}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] a0;
    logic [8:0] d0;
    for (int i = 0; i < 8; i++) begin mLvl[i] = 0; mMute[i] = 1; end
    for (int s = 0; s < 2; s++) begin sLvl[s] = 0; sMute[s] = 1; end
    mDig = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b0, "R1 reqReady in reset", reqReady, 0);
    chk(cmdValid == 1'b0, "R1 cmdValid in reset", cmdValid, 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b0, "R1 reqReady during start-up", reqReady, 0);
    for (int c = 0; c < 8; c++) pushChan(c);
    repeat (30) @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after start-up", reqReady, 1);
    compareQ("R1 start-up sequence");

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < N_STIM; i++) begin
      sendReq(int'(STIM[i][13:11]), int'(STIM[i][10:8]), int'(STIM[i][7:0]));
      repeat (20) @(negedge clk);
      compareQ($sformatf("R2/R3/R4/R5/R6/R7/R8 step %0d", i));
    end

    // R10 and R9: stall the command port, hold a second request
    cmdReady = 1'b0;
    sendReq(0, 1, 127);
    @(negedge clk);
    a0 = cmdAddr; d0 = cmdData;
    repeat (4) @(negedge clk);
    chk(cmdValid == 1'b1, "R10 valid held", cmdValid, 1);
    chk({cmdAddr, cmdData} == {a0, d0}, "R10 command held", int'({cmdAddr, cmdData}), int'({a0, d0}));
    chk(seenQ.size() == 0, "R10 nothing taken", seenQ.size(), 0);
    @(posedge clk); #1;
    reqValid = 1'b1; reqKind = 3'd0; reqIndex = 3'd1; reqValue = 8'd50;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b0, "R9 request held while busy", reqReady, 0);
    @(posedge clk); #1 cmdReady = 1'b1;
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    modelApply(0, 1, 50);
    @(posedge clk); #1 reqValid = 1'b0;
    repeat (20) @(negedge clk);
    compareQ("R9 held request follows");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule